// File: doc/BRIEF.md
# Phase Accumulator Oscillator with Noise Register

This block is one voice oscillator of a sound-synthesis engine. A 24-bit phase accumulator advances by a 16-bit frequency word on each cycle in which the clock-enable input is high. A 23-bit linear feedback shift register, which provides the noise source, steps whenever a fixed accumulator bit rises. Waveform shaping, envelopes and filtering are handled elsewhere. This block exports the raw phase, the noise register contents, an MSB-rising strobe, and the control fields that later stages decode.

Several voices can be chained for hard sync. Each voice's `msb_rise` and `sync_hit` outputs drive the `sync_src_rise` and `sync_src_hit` inputs of the next voice. Both strobes are combinational from the current state, so every voice advances on the same edge and the clearing decision is settled in that same cycle. A destination is not cleared when its source is being cleared on the cycle that the source's own MSB rises.

Software writes the configuration one byte at a time. Address 0 is the low frequency byte, address 1 is the high frequency byte and address 2 is the control byte.

Top module: `phase_osc_noise`

## Requirements
- R1: After reset, `acc` is 0, `noise` is 0x7FFFF8, `msb_rise` and `sync_hit` are 0, and the frequency word and control fields are 0.
- R2: A write to address 0 loads frequency bits 7:0 and a write to address 1 loads bits 15:8. On each edge with `clk_en` high, test clear and no sync clear, `acc` becomes (`acc` + frequency) mod 2^24.
- R3: On an edge with `clk_en` low, `acc` and `noise` keep their values unless test is set, and register writes still land. A write takes effect from the next enabled cycle.
- R4: Control bit 3 is test. On every edge while it is set, `acc` is cleared, and neither `acc` nor `noise` advances. After test is cleared, counting resumes from 0.
- R5: `noise` steps exactly on the enabled edges where accumulator bit 19 goes from 0 to 1 during the advance. On a step, `noise` shifts left by one and the new bit 0 is old bit 22 XOR old bit 17. `noise` is never zero.
- R6: `msb_rise` is high during a cycle exactly when `clk_en` is high, test is clear, `acc[23]` is 0 and bit 23 of `acc` + frequency is 1.
- R7: Control bit 1 is sync enable. `sync_hit` equals `clk_en` AND sync enable AND `sync_src_rise`. When `sync_hit` is high and `sync_src_hit` is low, `acc` is 0 after the edge.
- R8: When `sync_hit` and `sync_src_hit` are both high, `acc` advances normally instead of clearing.
- R9: Control bits 7:4 appear on `wave_sel` and control bit 2 appears on `ring_en`. Control bit 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | One-cycle advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 freq low, 1 freq high, 2 control |
| wr_data | input | 8 | Write data byte |
| sync_src_rise | input | 1 | MSB-rising strobe of the sync source |
| sync_src_hit | input | 1 | Sync source is itself being cleared this cycle |
| acc | output | 24 | Phase accumulator |
| noise | output | 23 | Noise shift register |
| msb_rise | output | 1 | Accumulator MSB rises on this cycle's advance |
| sync_hit | output | 1 | This voice is sync-cleared this cycle |
| wave_sel | output | 4 | Waveform select field |
| ring_en | output | 1 | Ring-modulation enable field |

## Verification
The embedded assertions check five behaviours on every cycle:
- the phase step;
- the hold while idle;
- the clear under test and on sync;
- the shift relation of the noise register and its nonzero invariant;
- the fact that the MSB is set after a rise strobe.

Only the bench scenarios can show the following:
- that the noise register steps at exactly the right edges with the right feedback, which needs an independent model of both registers over long sweeps of frequency words and enable patterns;
- the same-cycle sync exception;
- the byte placement of writes;
- the fact that the gate bit is ignored.

// File: rtl/phase_osc_noise.sv
module phase_osc_noise #(
  parameter logic [22:0] NOISE_SEED = 23'h7FFFF8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clk_en,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        sync_src_rise,
  input  logic        sync_src_hit,
  output logic [23:0] acc,
  output logic [22:0] noise,
  output logic        msb_rise,
  output logic        sync_hit,
  output logic [3:0]  wave_sel,
  output logic        ring_en
);
  localparam int ACC_W    = 24;
  localparam int NOISE_W  = 23;
  localparam int STEP_BIT = 19;
  localparam int TAP_HI   = NOISE_W - 1;
  localparam int TAP_LO   = 17;
  localparam int MSB      = ACC_W - 1;

  logic [ACC_W-1:0]   acc_q, sum;
  logic [NOISE_W-1:0] noise_q;
  logic [15:0]        freq_q;
  logic [3:0]         wave_q;
  logic               test_q, ring_q, sync_q;
  logic               advance, step_noise, clear_now;

  assign sum        = acc_q + {8'h00, freq_q};
  assign advance    = clk_en && !test_q;
  assign msb_rise   = advance && !acc_q[MSB] && sum[MSB];
  assign step_noise = advance && !acc_q[STEP_BIT] && sum[STEP_BIT];
  assign sync_hit   = clk_en && sync_q && sync_src_rise;
  assign clear_now  = sync_hit && !sync_src_hit;

  assign acc      = acc_q;
  assign noise    = noise_q;
  assign wave_sel = wave_q;
  assign ring_en  = ring_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      noise_q <= NOISE_SEED;
    end else begin
      if (test_q)
        acc_q <= '0;
      else if (clk_en)
        acc_q <= clear_now ? '0 : sum;
      if (step_noise)
        noise_q <= {noise_q[NOISE_W-2:0], noise_q[TAP_HI] ^ noise_q[TAP_LO]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_q <= '0;
      wave_q <= '0;
      test_q <= 1'b0;
      ring_q <= 1'b0;
      sync_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: freq_q[7:0]  <= wr_data;
        2'd1: freq_q[15:8] <= wr_data;
        2'd2: begin
          wave_q <= wr_data[7:4];
          test_q <= wr_data[3];
          ring_q <= wr_data[2];
          sync_q <= wr_data[1];
        end
        default: ;
      endcase
    end
  end

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !clear_now |=> acc_q == $past(sum));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en && !test_q |=> $stable(acc_q) && $stable(noise_q));
  // R4
  test_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_q |=> acc_q == '0 && $stable(noise_q));
  // R5
  noise_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_noise |=> noise_q[NOISE_W-1:1] == $past(noise_q[NOISE_W-2:0]));
  // R5
  noise_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    noise_q != '0);
  // R6
  msb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msb_rise && !clear_now |=> acc_q[MSB]);
  // R7
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_now |=> acc_q == '0);
endmodule

// File: tb/phase_osc_noise_tb.sv
module phase_osc_noise_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic sync_src_rise = 1'b0, sync_src_hit = 1'b0;
  logic [23:0] acc;
  logic [22:0] noise;
  logic msb_rise, sync_hit, ring_en;
  logic [3:0] wave_sel;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [23:0] m_acc;
  logic [22:0] m_noise;
  logic [15:0] m_freq;
  logic [3:0]  m_wave;
  logic        m_test, m_ring, m_sync;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_osc_noise dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_src_rise(sync_src_rise), .sync_src_hit(sync_src_hit),
    .acc(acc), .noise(noise), .msb_rise(msb_rise), .sync_hit(sync_hit),
    .wave_sel(wave_sel), .ring_en(ring_en));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit en, input bit we, input logic [1:0] a, input logic [7:0] d,
                     input bit sr, input bit sh, input string tag);
    logic [23:0] sum;
    bit exp_rise, exp_hit;
    clk_en = en; wr_en = we; wr_addr = a; wr_data = d;
    sync_src_rise = sr; sync_src_hit = sh;
    #1;
    sum = m_acc + {8'h00, m_freq};
    exp_rise = en && !m_test && !m_acc[23] && sum[23];
    exp_hit  = en && m_sync && sr;
    chk(msb_rise === exp_rise, "R6 msb_rise", 32'(msb_rise), 32'(exp_rise));
    chk(sync_hit === exp_hit, "R7 sync_hit", 32'(sync_hit), 32'(exp_hit));
    @(posedge clk);
    if (m_test) m_acc = '0;
    else if (en) begin
      if (!m_acc[19] && sum[19]) m_noise = {m_noise[21:0], m_noise[22] ^ m_noise[17]};
      m_acc = (exp_hit && !sh) ? 24'h0 : sum;
    end
    if (we) begin
      case (a)
        2'd0: m_freq[7:0] = d;
        2'd1: m_freq[15:8] = d;
        2'd2: begin m_wave = d[7:4]; m_test = d[3]; m_ring = d[2]; m_sync = d[1]; end
        default: ;
      endcase
    end
    @(negedge clk);
    chk(acc === m_acc, tag, 32'(acc), 32'(m_acc));
    chk(noise === m_noise, "R5 noise", 32'(noise), 32'(m_noise));
    chk(noise !== 23'h0, "R5 noise nonzero", 32'(noise), 32'h1);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, a, d, 1'b0, 1'b0, "R3 write idle");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_acc = '0; m_noise = 23'h7FFFF8; m_freq = '0;
    m_wave = '0; m_test = 0; m_ring = 0; m_sync = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(acc === 24'h0, "R1 acc", 32'(acc), 0);
    chk(noise === 23'h7FFFF8, "R1 noise", 32'(noise), 32'h7FFFF8);
    chk(msb_rise === 1'b0, "R1 msb_rise", 32'(msb_rise), 0);
    chk(sync_hit === 1'b0, "R1 sync_hit", 32'(sync_hit), 0);
    chk(wave_sel === 4'h0 && ring_en === 1'b0, "R1 ctrl", 32'({wave_sel, ring_en}), 0);
    @(negedge clk);

    // R2 R5 R6: sweeps over frequency words and enable patterns
    foreach (m_freq[i]) ; // no-op keeps style compact
    for (int f = 0; f < 4; f++) begin
      logic [15:0] fw;
      fw = (f == 0) ? 16'hFFFF : (f == 1) ? 16'h8001 : (f == 2) ? 16'h1234 : 16'hF00F;
      wr(2'd0, fw[7:0]);
      wr(2'd1, fw[15:8]);
      for (int c = 0; c < 700; c++)
        cyc((c % 3) != 2 || f[0], 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, "R2 acc advance");
    end

    // R3: writes with enable low do not move acc; enabled cycles afterwards use new word
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h10);
    for (int c = 0; c < 20; c++)
      cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, "R3 idle hold");
    for (int c = 0; c < 40; c++)
      cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, "R3 new word");

    // R4: test bit clears and holds, then restart from zero
    wr(2'd2, 8'h08);
    for (int c = 0; c < 10; c++)
      cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, "R4 test hold");
    chk(acc === 24'h0, "R4 acc zero", 32'(acc), 0);
    wr(2'd2, 8'h00);
    for (int c = 0; c < 10; c++)
      cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, "R4 resume");

    // R7 R8: sync clear and same-cycle exception
    wr(2'd2, 8'h02);
    for (int c = 0; c < 5; c++)
      cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, "R7 before sync");
    cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, "R7 sync clear");
    chk(acc === 24'h0, "R7 acc cleared", 32'(acc), 0);
    for (int c = 0; c < 5; c++)
      cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, "R7 after sync");
    cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1, "R8 sync suppressed");
    chk(acc !== 24'h0, "R8 acc kept", 32'(acc), 32'(m_acc));
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, "R7 no clear when idle");

    // R9: field outputs, gate bit has no effect
    wr(2'd2, 8'hA5);
    chk(wave_sel === 4'hA, "R9 wave_sel", 32'(wave_sel), 32'hA);
    chk(ring_en === 1'b1, "R9 ring_en", 32'(ring_en), 1);
    for (int c = 0; c < 30; c++)
      cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, "R9 gate ignored");
    wr(2'd2, 8'h50);
    chk(wave_sel === 4'h5 && ring_en === 1'b0, "R9 fields", 32'({wave_sel, ring_en}), 32'h0A);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule